// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block listens passively on the two wires of an I2C or SMBus bus and decides whether a transfer is aimed at this device. It brings SCL and SDA into the system clock domain and detects start, repeated start and stop conditions. It shifts in the address byte, or the two address bytes, that follow each start. The captured address is compared at the same time against three address slots. Each slot has its own enable and its own choice of 7-bit or 10-bit format, so both formats can be answered at once. Separately, the block recognises the general call, device ID and SMBus host addresses, each under its own enable.

A match gives a one-cycle pulse, the index of the slot that matched and the read/write bit of the address. The host logic uses these results to take part in the transfer or to stay silent. Data bytes after the address phase, acknowledge driving and clock stretching are handled elsewhere.

The controller is a five-state machine. IDLE is the state between transfers. BYTE1 receives the first address byte. ACK1 skips the acknowledge clock after a 10-bit high-byte hit. BYTE2 receives the 10-bit low byte. HOLD waits out the rest of the transfer. The transitions are as follows:
- Any start or repeated start goes to BYTE1 from every state.
- A stop goes to IDLE from every state.
- BYTE1 goes to ACK1 after a 10-bit write prefix that hits at least one slot, and to HOLD after any other byte.
- ACK1 goes to BYTE2 on the next SCL rise.
- BYTE2 goes to HOLD when its byte is complete.

Top module: `i2c_addr_match`

## Requirements
- R1: A falling SDA while SCL is high pulses `start_pulse` when the bus was idle, or `rstart_pulse` when a transfer was already open. A rising SDA while SCL is high pulses `stop_pulse`. At most one of the three is high in any cycle, and all outputs are 0 after reset.
- R2: For a 7-bit slot, the first byte after a start matches when its bits [7:1] equal slot bits [6:0] and the slot is enabled. The match pulses `match_pulse` and gives the slot index on `match_slot`. Slot i occupies `slot_addr[10*i+9:10*i]`.
- R3: A disabled slot never matches. A slot in 10-bit format (`slot_ten[i]`=1) never matches a 7-bit address byte.
- R4: When several slots match the same address, the lowest slot index is reported.
- R5: A 10-bit write matches when the first byte is `11110`, then slot bits [9:8], then 0, and the second byte after the acknowledge clock equals slot bits [7:0]. A wrong second byte gives no match.
- R6: A first byte `11110`+[9:8]+1 after a repeated start matches with read direction only if the address phase just before it was a matching 10-bit write to that slot. Without such a write, for example straight after a stop and a start, it does not match.
- R7: With `gc_en`=1, a first byte of 0x00 pulses `gc_hit`. A read of address 0 (0x01), or any byte while `gc_en`=0, does not.
- R8: With `devid_en`=1, a 7-bit address of 1111100 pulses `devid_hit` for either direction.
- R9: With `host_en`=1, a 7-bit address of 0001000 pulses `host_hit`.
- R10: A stop or a start in the middle of an address byte abandons that byte with no match. A start restarts address capture from its first bit.
- R11: `match_rw` takes bit 0 of every completed first address byte (1 = read) and holds it until the next one.
- R12: Slots in 7-bit and 10-bit format are active together, and both can match within one transfer joined by a repeated start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line (asynchronous) |
| slot_en | input | NSLOT | Per-slot enable |
| slot_ten | input | NSLOT | Per-slot 10-bit format select |
| slot_addr | input | 10*NSLOT | Slot addresses; 7-bit slots use bits [6:0] |
| gc_en | input | 1 | General call detection enable |
| devid_en | input | 1 | Device ID address detection enable |
| host_en | input | 1 | SMBus host address detection enable |
| start_pulse | output | 1 | Start on an idle bus |
| rstart_pulse | output | 1 | Repeated start |
| stop_pulse | output | 1 | Stop detected |
| match_pulse | output | 1 | A slot matched the address |
| match_slot | output | SW | Index of the matching slot |
| match_rw | output | 1 | R/W bit of the last address (1 = read) |
| gc_hit | output | 1 | General call recognised |
| devid_hit | output | 1 | Device ID address recognised |
| host_hit | output | 1 | SMBus host address recognised |

## Verification
The hardest case to reach is the 10-bit read. It needs a full 10-bit write address that matches, then a repeated start with no stop between, then the read form of the high byte. Only that exact sequence may produce a match. The bench builds this chain in one bit-banged transfer. It then sends the same read byte after a fresh stop and start, where no match may appear. Aborted addresses are produced by partial-byte tasks that cut a byte off with a stop or a restart after a few bits.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BYTE1,
        ST_ACK1,
        ST_BYTE2,
        ST_HOLD
    } am_state_t;

    localparam int         ADDR_W     = 10;
    localparam logic [4:0] TEN_PREFIX = 5'b11110;
    localparam logic [6:0] DEVID_ADDR = 7'b1111100;
    localparam logic [6:0] HOST_ADDR  = 7'b0001000;
    localparam logic [7:0] GCALL_BYTE = 8'h00;
endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic sda_s,
    output logic start_s,
    output logic stop_s
);
    logic [1:0] scl_ff;
    logic [1:0] sda_ff;
    logic       scl_d;
    logic       sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= 2'b11;
            sda_ff <= 2'b11;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[0], scl_i};
            sda_ff <= {sda_ff[0], sda_i};
            scl_d  <= scl_ff[1];
            sda_d  <= sda_ff[1];
        end
    end

    assign sda_s    = sda_ff[1];
    assign scl_rise = scl_ff[1] & ~scl_d;
    assign start_s  = scl_ff[1] & scl_d & sda_d & ~sda_ff[1];
    assign stop_s   = scl_ff[1] & scl_d & ~sda_d & sda_ff[1];
endmodule

// File: rtl/i2c_am_rx.sv
module i2c_am_rx #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            take,
    input  logic            sda,
    output logic [BITS-1:0] byte_o,
    output logic            done_o
);
    localparam int CW = $clog2(BITS);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    logic [CW-1:0]   cnt;
    logic [BITS-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            sh     <= '0;
            done_o <= 1'b0;
        end else if (clr) begin
            cnt    <= '0;
            done_o <= 1'b0;
        end else if (take) begin
            sh <= {sh[BITS-2:0], sda};
            if (cnt == LAST) begin
                cnt    <= '0;
                done_o <= 1'b1;
            end else begin
                cnt    <= cnt + 1'b1;
                done_o <= 1'b0;
            end
        end else begin
            done_o <= 1'b0;
        end
    end

    assign byte_o = sh;
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp
    import i2c_am_pkg::*;
#(
    parameter int NSLOT = 3
) (
    input  logic [7:0]              byte_i,
    input  logic [NSLOT-1:0]        slot_en,
    input  logic [NSLOT-1:0]        slot_ten,
    input  logic [ADDR_W*NSLOT-1:0] slot_addr,
    input  logic [NSLOT-1:0]        cand_i,
    output logic [NSLOT-1:0]        hit7,
    output logic [NSLOT-1:0]        hit10hi,
    output logic [NSLOT-1:0]        hit10lo,
    output logic                    is_pfx,
    output logic                    is_gc,
    output logic                    is_dev,
    output logic                    is_host
);
    assign is_pfx  = (byte_i[7:3] == TEN_PREFIX);
    assign is_gc   = (byte_i == GCALL_BYTE);
    assign is_dev  = (byte_i[7:1] == DEVID_ADDR);
    assign is_host = (byte_i[7:1] == HOST_ADDR);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic [ADDR_W-1:0] a;
        assign a          = slot_addr[ADDR_W*i +: ADDR_W];
        assign hit7[i]    = slot_en[i] & ~slot_ten[i] & ~is_pfx & (byte_i[7:1] == a[6:0]);
        assign hit10hi[i] = slot_en[i] & slot_ten[i] & is_pfx & (byte_i[2:1] == a[9:8]);
        assign hit10lo[i] = cand_i[i] & slot_en[i] & (byte_i == a[7:0]);
    end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
    import i2c_am_pkg::*;
#(
    parameter  int NSLOT = 3,
    localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic [NSLOT-1:0]        slot_en,
    input  logic [NSLOT-1:0]        slot_ten,
    input  logic [ADDR_W*NSLOT-1:0] slot_addr,
    input  logic                    gc_en,
    input  logic                    devid_en,
    input  logic                    host_en,
    output logic                    start_pulse,
    output logic                    rstart_pulse,
    output logic                    stop_pulse,
    output logic                    match_pulse,
    output logic [SW-1:0]           match_slot,
    output logic                    match_rw,
    output logic                    gc_hit,
    output logic                    devid_hit,
    output logic                    host_hit
);
    logic scl_rise, sda_s, start_s, stop_s;
    logic rx_clr, rx_take, rx_done;
    logic [7:0] rx_byte;
    logic [NSLOT-1:0] hit7, hit10hi, hit10lo, cand_q;
    logic is_pfx, is_gc, is_dev, is_host;
    logic busy_q, armed_v;
    logic [SW-1:0] armed_slot, p7, plo;
    logic in_byte, rw_bit;
    am_state_t state, nstate;

    i2c_am_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .sda_s(sda_s), .start_s(start_s), .stop_s(stop_s)
    );

    assign in_byte = (state == ST_BYTE1) || (state == ST_BYTE2);
    assign rx_clr  = ~in_byte | start_s | stop_s;
    assign rx_take = scl_rise & in_byte;

    i2c_am_rx #(.BITS(8)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .take(rx_take),
        .sda(sda_s), .byte_o(rx_byte), .done_o(rx_done)
    );

    i2c_am_cmp #(.NSLOT(NSLOT)) u_cmp (
        .byte_i(rx_byte), .slot_en(slot_en), .slot_ten(slot_ten),
        .slot_addr(slot_addr), .cand_i(cand_q),
        .hit7(hit7), .hit10hi(hit10hi), .hit10lo(hit10lo),
        .is_pfx(is_pfx), .is_gc(is_gc), .is_dev(is_dev), .is_host(is_host)
    );

    assign rw_bit = rx_byte[0];

    always_comb begin
        p7  = '0;
        plo = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (hit7[i])    p7  = SW'(i);
            if (hit10lo[i]) plo = SW'(i);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // next state
    always_comb begin
        nstate = state;
        if (start_s) begin
            nstate = ST_BYTE1;
        end else if (stop_s) begin
            nstate = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nstate = ST_IDLE;
                ST_BYTE1: if (rx_done)
                              nstate = (is_pfx && !rw_bit && (|hit10hi)) ? ST_ACK1 : ST_HOLD;
                ST_ACK1:  if (scl_rise) nstate = ST_BYTE2;
                ST_BYTE2: if (rx_done) nstate = ST_HOLD;
                ST_HOLD:  nstate = ST_HOLD;
                default:  nstate = ST_IDLE;
            endcase
        end
    end

    // outputs and address-phase state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_pulse  <= 1'b0;
            rstart_pulse <= 1'b0;
            stop_pulse   <= 1'b0;
            match_pulse  <= 1'b0;
            match_slot   <= '0;
            match_rw     <= 1'b0;
            gc_hit       <= 1'b0;
            devid_hit    <= 1'b0;
            host_hit     <= 1'b0;
            busy_q       <= 1'b0;
            armed_v      <= 1'b0;
            armed_slot   <= '0;
            cand_q       <= '0;
        end else begin
            start_pulse  <= start_s & ~busy_q;
            rstart_pulse <= start_s & busy_q;
            stop_pulse   <= stop_s;
            match_pulse  <= 1'b0;
            gc_hit       <= 1'b0;
            devid_hit    <= 1'b0;
            host_hit     <= 1'b0;
            if (start_s) busy_q <= 1'b1;
            else if (stop_s) busy_q <= 1'b0;

            if (stop_s) begin
                armed_v <= 1'b0;
                cand_q  <= '0;
            end else if (start_s) begin
                cand_q <= '0;
                if (!busy_q) armed_v <= 1'b0;
            end else if (state == ST_BYTE1 && rx_done) begin
                match_rw <= rw_bit;
                armed_v  <= 1'b0;
                if (is_pfx) begin
                    if (!rw_bit) begin
                        cand_q <= hit10hi;
                    end else if (armed_v && hit10hi[armed_slot]) begin
                        match_pulse <= 1'b1;
                        match_slot  <= armed_slot;
                    end
                end else begin
                    if (|hit7) begin
                        match_pulse <= 1'b1;
                        match_slot  <= p7;
                    end
                    gc_hit    <= gc_en & is_gc;
                    devid_hit <= devid_en & is_dev;
                    host_hit  <= host_en & is_host;
                end
            end else if (state == ST_BYTE2 && rx_done) begin
                cand_q <= '0;
                if (|hit10lo) begin
                    match_pulse <= 1'b1;
                    match_slot  <= plo;
                    armed_v     <= 1'b1;
                    armed_slot  <= plo;
                end
            end
        end
    end

    a_r1_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_pulse, rstart_pulse, stop_pulse}));

    a_r10_stop_abandons: assert property (@(posedge clk) disable iff (!rst_n)
        stop_s |=> (state == ST_IDLE));

    a_r10_start_recaptures: assert property (@(posedge clk) disable iff (!rst_n)
        start_s |=> (state == ST_BYTE1));

    a_r3_match_enabled_slot: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> slot_en[match_slot]);

    a_r7_gc_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        gc_hit |-> !match_rw);

    a_r6_read_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (match_pulse && match_rw && slot_ten[match_slot]) |-> $past(armed_v));
endmodule

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;
    localparam int CLK_PERIOD = 10;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1;
    logic [2:0] slot_en, slot_ten;
    logic [29:0] slot_addr;
    logic gc_en, devid_en, host_en;
    logic start_pulse, rstart_pulse, stop_pulse, match_pulse, match_rw;
    logic [1:0] match_slot;
    logic gc_hit, devid_hit, host_hit;

    int n_chk = 0, n_bad = 0;
    int n_match = 0, n_start = 0, n_rstart = 0, n_stop = 0;
    int n_gc = 0, n_dev = 0, n_host = 0;
    int last_slot = -1, last_rw = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_addr_match u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .slot_en(slot_en), .slot_ten(slot_ten), .slot_addr(slot_addr),
        .gc_en(gc_en), .devid_en(devid_en), .host_en(host_en),
        .start_pulse(start_pulse), .rstart_pulse(rstart_pulse), .stop_pulse(stop_pulse),
        .match_pulse(match_pulse), .match_slot(match_slot), .match_rw(match_rw),
        .gc_hit(gc_hit), .devid_hit(devid_hit), .host_hit(host_hit)
    );

    always @(negedge clk) if (rst_n) begin
        if (match_pulse) begin
            n_match++;
            last_slot = int'(match_slot);
            last_rw = int'(match_rw);
        end
        if (start_pulse)  n_start++;
        if (rstart_pulse) n_rstart++;
        if (stop_pulse)   n_stop++;
        if (gc_hit)    n_gc++;
        if (devid_hit) n_dev++;
        if (host_hit)  n_host++;
    end

    task automatic check(input int act, input int exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda = 1'b0; hw(H); scl = 1'b0; hw(H);
    endtask

    task automatic bus_restart;
        sda = 1'b1; hw(H); scl = 1'b1; hw(H); sda = 1'b0; hw(H); scl = 1'b0; hw(H);
    endtask

    task automatic bus_stop;
        sda = 1'b0; hw(H); scl = 1'b1; hw(H); sda = 1'b1; hw(2*H);
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda = v[i]; hw(H); scl = 1'b1; hw(H); scl = 1'b0;
        end
        hw(H);
    endtask

    task automatic send_byte(input logic [7:0] v);
        send_bits(v, 8);
        sda = 1'b1; hw(H); scl = 1'b1; hw(H); scl = 1'b0; hw(H);
    endtask

    task automatic one_addr(input logic [7:0] v);
        bus_start; send_byte(v); bus_stop;
    endtask

    task automatic t_reset;
        check(int'({start_pulse, rstart_pulse, stop_pulse, match_pulse}), 0, "R1 reset pulses");
        check(int'({match_slot, match_rw, gc_hit, devid_hit, host_hit}), 0, "R1 reset outputs");
    endtask

    task automatic t_seven_write;
        int m = n_match, s = n_start, p = n_stop;
        one_addr(8'h54);
        check(n_match - m, 1, "R2 7-bit write match");
        check(last_slot, 0, "R2 slot index");
        check(last_rw, 0, "R11 write rw");
        check(n_start - s, 1, "R1 start pulse");
        check(n_stop - p, 1, "R1 stop pulse");
    endtask

    task automatic t_seven_read;
        int m = n_match;
        one_addr(8'h55);
        check(n_match - m, 1, "R2 7-bit read match");
        check(last_rw, 1, "R11 read rw");
        check(int'(match_rw), 1, "R11 match_rw held");
    endtask

    task automatic t_nomatch;
        int m = n_match;
        one_addr(8'h56);
        check(n_match - m, 0, "R3 foreign address");
        one_addr(8'h6A);
        check(n_match - m, 0, "R3 10-bit slot ignores 7-bit byte");
        check(int'(match_rw), 0, "R11 rw follows non-matching byte");
    endtask

    task automatic t_priority;
        int m = n_match;
        slot_en = 3'b101;
        one_addr(8'h54);
        check(n_match - m, 1, "R4 shared address one pulse");
        check(last_slot, 0, "R4 lowest slot wins");
        slot_en = 3'b100;
        one_addr(8'h54);
        check(last_slot, 2, "R3 disabled slot skipped");
        slot_en = 3'b000;
        one_addr(8'h54);
        check(n_match - m, 2, "R3 all disabled");
        slot_en = 3'b011;
    endtask

    task automatic t_ten_write;
        int m = n_match;
        bus_start; send_byte(8'hF4); send_byte(8'hB5); bus_stop;
        check(n_match - m, 1, "R5 10-bit write match");
        check(last_slot, 1, "R5 10-bit slot index");
        check(last_rw, 0, "R5 10-bit write rw");
        bus_start; send_byte(8'hF4); send_byte(8'hB6); bus_stop;
        check(n_match - m, 1, "R5 wrong low byte");
        bus_start; send_byte(8'hF6); send_byte(8'hB5); bus_stop;
        check(n_match - m, 1, "R5 wrong high bits");
    endtask

    task automatic t_ten_read;
        int m = n_match, r = n_rstart;
        bus_start; send_byte(8'hF4); send_byte(8'hB5);
        bus_restart; send_byte(8'hF5); bus_stop;
        check(n_match - m, 2, "R6 10-bit read after write");
        check(last_rw, 1, "R6 read direction");
        check(last_slot, 1, "R6 read slot");
        check(n_rstart - r, 1, "R1 repeated start pulse");
        one_addr(8'hF5);
        check(n_match - m, 2, "R6 read without write");
        bus_start; send_byte(8'hF4); send_byte(8'hB5);
        bus_restart; send_byte(8'h54);
        bus_restart; send_byte(8'hF5); bus_stop;
        check(n_match - m, 4, "R6 intervening address disarms");
    endtask

    task automatic t_mixed;
        int m = n_match;
        bus_start; send_byte(8'h54);
        bus_restart; send_byte(8'hF4); send_byte(8'hB5); bus_stop;
        check(n_match - m, 2, "R12 mixed formats in one transfer");
        check(last_slot, 1, "R12 last slot 10-bit");
    endtask

    task automatic t_reserved;
        int g = n_gc, d = n_dev, h = n_host, m = n_match;
        one_addr(8'h00);
        check(n_gc - g, 1, "R7 general call");
        one_addr(8'h01);
        check(n_gc - g, 1, "R7 address 0 read ignored");
        gc_en = 1'b0; one_addr(8'h00); gc_en = 1'b1;
        check(n_gc - g, 1, "R7 disabled");
        one_addr(8'hF8); one_addr(8'hF9);
        check(n_dev - d, 2, "R8 device id both directions");
        devid_en = 1'b0; one_addr(8'hF8); devid_en = 1'b1;
        check(n_dev - d, 2, "R8 disabled");
        one_addr(8'h10);
        check(n_host - h, 1, "R9 host address");
        host_en = 1'b0; one_addr(8'h10); host_en = 1'b1;
        check(n_host - h, 1, "R9 disabled");
        check(n_match - m, 0, "R7 reserved no slot match");
    endtask

    task automatic t_abort;
        int m = n_match, p = n_stop, r = n_rstart;
        bus_start; send_bits(8'h54, 4); bus_stop;
        check(n_match - m, 0, "R10 stop mid-address");
        check(n_stop - p, 1, "R10 stop seen");
        bus_start; send_bits(8'hFF, 3); bus_restart; send_byte(8'h54); bus_stop;
        check(n_match - m, 1, "R10 restart recaptures");
        check(n_rstart - r, 1, "R10 restart seen");
        bus_start; send_byte(8'hF4); send_bits(8'hB5, 5); bus_stop;
        check(n_match - m, 1, "R10 abort in low byte");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        slot_en = 3'b011;
        slot_ten = 3'b010;
        slot_addr = {10'h02A, 10'h2B5, 10'h02A};
        gc_en = 1'b1; devid_en = 1'b1; host_en = 1'b1;
        hw(5);
        rst_n = 1'b1;
        hw(5);
        t_reset;
        t_seven_write;
        t_seven_read;
        t_nomatch;
        t_priority;
        t_ten_write;
        t_ten_read;
        t_mixed;
        t_reserved;
        t_abort;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule